// File: doc/BRIEF.md
# Paged Write-Commit Buffer for a Byte-Wide Nonvolatile Array

This block sits behind a serial-bus slave front end and turns a stream of already decoded bus events into page programming of a 256-entry, 8-bit nonvolatile store. The front end hands it three kinds of event: a byte-address strobe that positions the pointer, a data strobe carrying one received byte, and a pulse marking the stop condition. Data bytes collect in a 16-slot page buffer rather than going straight to the array. A valid bit is kept for each slot.

When a stop arrives after at least one byte, the block starts a self-timed programming window. The window length is set by a parameter in system clock cycles. While the window runs, `busy` is high, and the front end uses it to ignore its slave address and withhold acknowledges. At the last cycle of the window, every slot marked valid is copied into the array in one step. A separate registered read port gives access to the array, and the current address pointer is exported so that the front end can serve reads from the current address.

Top module: `pgw_top`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `ptr_out` is 0x00 and every array location reads 0xFF.
- R2: An `addr_load` strobe while not busy sets `ptr_out` to `addr_in` on the next cycle and discards every buffered byte that was not yet committed.
- R3: A data byte accepted while not busy goes into the buffer slot given by `ptr_out[3:0]`. The low four pointer bits then increment modulo 16, and the high four bits stay unchanged.
- R4: When more than 16 bytes arrive before a stop, the slot index wraps inside the page, and a later byte replaces the earlier byte in the same slot.
- R5: A stop that follows at least one accepted data byte raises `busy` on the next cycle, and `busy` stays high for exactly `WR_CYCLES` cycles.
- R6: A stop with no buffered data leaves `busy` low, changes no array location, and leaves the loaded pointer in place.
- R7: The array keeps its old contents while `busy` is high. When `busy` falls, exactly the slots written since the last address load or commit appear at page `ptr_out[7:4]`, and the other addresses of that page keep their values.
- R8: While `busy` is high, `addr_load`, `data_stb` and `stop_pulse` have no effect on the pointer, the buffer or the array.
- R9: After a commit, `ptr_out` equals the last written address plus one, with the increment wrapping inside the page.
- R10: A data strobe in the same cycle as a stop is buffered and included in the commit that the stop starts. A data strobe in the same cycle as an address load is dropped.
- R11: `rd_data` shows the array content at the `rd_addr` that was presented one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Byte-address strobe from the bus front end |
| addr_in | input | 8 | Byte address to load |
| data_stb | input | 1 | Received data byte strobe |
| data_in | input | 8 | Received data byte |
| stop_pulse | input | 1 | One-cycle stop-condition pulse |
| rd_addr | input | 8 | Read port address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | Programming window in progress |
| ptr_out | output | 8 | Current address pointer |

## Verification
Two functions can fall in the same cycle. The first pair is the last data byte and the stop: the bench drives `data_stb` and `stop_pulse` on the same edge and expects that byte in the committed page, with `busy` rising one cycle later. The second pair is an address load and a data strobe: the bench drives both together and judges the result by the pointer, by a following stop that must not start a window, and by the array contents. The bench also provokes a read of a location that is being programmed during the window, and expects the old value until `busy` falls.

// File: rtl/pgw_pkg.sv
`timescale 1ns/1ps
// Package pgw_pkg: shared defaults, timer state type and the in-page
// pointer increment used by the write buffer. Assumes the page size is a
// power of two and is smaller than the address space.
package pgw_pkg;
    localparam int DEF_ADDR_W    = 8;
    localparam int DEF_DATA_W    = 8;
    localparam int DEF_PAGE_W    = 4;
    localparam int DEF_WR_CYCLES = 1000;

    typedef enum logic {TMR_IDLE = 1'b0, TMR_RUN = 1'b1} tmr_state_t;

    // Advance the low PAGE_W bits and keep the page bits.
    function automatic logic [DEF_ADDR_W-1:0] next_in_page(
        input logic [DEF_ADDR_W-1:0] p
    );
        logic [DEF_ADDR_W-1:0] r;
        r = p;
        r[DEF_PAGE_W-1:0] = p[DEF_PAGE_W-1:0] + 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pgw_pointer.sv
`timescale 1ns/1ps
// pgw_pointer: address pointer register. It loads on an accepted address
// strobe and advances inside the page on an accepted data byte. It assumes
// that the strobes are already gated by busy in the top.
module pgw_pointer #(
    parameter int ADDR_W = pgw_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              acc_data,
    output logic [ADDR_W-1:0] ptr
);
    import pgw_pkg::*;

    // Pointer update: load takes priority over advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (acc_load) begin
            ptr <= addr_in;
        end else if (acc_data) begin
            ptr <= next_in_page(ptr);
        end
    end
endmodule

// File: rtl/pgw_pagebuf.sv
`timescale 1ns/1ps
// pgw_pagebuf: one page of byte slots, each with a valid flag. A write
// fills the slot picked by the pointer's low bits. The flags clear on an
// address load or on a commit. It assumes that a write and a clear never
// come in the same cycle.
module pgw_pagebuf #(
    parameter int DATA_W = pgw_pkg::DEF_DATA_W,
    parameter int PAGE_W = pgw_pkg::DEF_PAGE_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           wr,
    input  logic [PAGE_W-1:0]              slot,
    input  logic [DATA_W-1:0]              wdata,
    output logic [(1<<PAGE_W)*DATA_W-1:0]  slot_data,
    output logic [(1<<PAGE_W)-1:0]         slot_vld
);
    localparam int PAGE_N = 1 << PAGE_W;

    for (genvar i = 0; i < PAGE_N; i++) begin : g_slot
        logic [DATA_W-1:0] byte_q;
        logic              vld_q;

        // Slot storage: capture on a matching write, drop the flag on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else if (clear) begin
                vld_q  <= 1'b0;
            end else if (wr && (slot == PAGE_W'(i))) begin
                byte_q <= wdata;
                vld_q  <= 1'b1;
            end
        end

        assign slot_data[i*DATA_W +: DATA_W] = byte_q;
        assign slot_vld[i]                   = vld_q;
    end
endmodule

// File: rtl/pgw_timer.sv
`timescale 1ns/1ps
// pgw_timer: self-timed programming window. A start while idle holds busy
// for exactly WR_CYCLES cycles. The commit pulse comes in the last of
// them, at the edge where busy falls. It assumes WR_CYCLES >= 1.
module pgw_timer #(
    parameter int WR_CYCLES = pgw_pkg::DEF_WR_CYCLES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic commit
);
    import pgw_pkg::*;

    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    tmr_state_t       state_q;
    logic [CNT_W-1:0] left_q;

    // Window sequencing: load the count on start, count down while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TMR_IDLE;
            left_q  <= '0;
        end else begin
            case (state_q)
                TMR_IDLE: if (start) begin
                    state_q <= TMR_RUN;
                    left_q  <= CNT_W'(WR_CYCLES - 1);
                end
                TMR_RUN: if (left_q == '0) begin
                    state_q <= TMR_IDLE;
                end else begin
                    left_q <= left_q - 1'b1;
                end
                default: state_q <= TMR_IDLE;
            endcase
        end
    end

    // Outputs decoded from the state and the remaining count.
    always_comb begin
        busy   = (state_q == TMR_RUN);
        commit = busy && (left_q == '0);
    end
endmodule

// File: rtl/pgw_array.sv
`timescale 1ns/1ps
// pgw_array: byte array model of the nonvolatile store. On commit, each
// valid slot of the page buffer is written into the page given by
// page_sel. The read port is registered. It assumes that the slot index
// fills the low address bits.
module pgw_array #(
    parameter int ADDR_W = pgw_pkg::DEF_ADDR_W,
    parameter int DATA_W = pgw_pkg::DEF_DATA_W,
    parameter int PAGE_W = pgw_pkg::DEF_PAGE_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          commit,
    input  logic [ADDR_W-PAGE_W-1:0]      page_sel,
    input  logic [(1<<PAGE_W)*DATA_W-1:0] slot_data,
    input  logic [(1<<PAGE_W)-1:0]        slot_vld,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int PAGE_N = 1 << PAGE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage: erased pattern on reset, masked page write on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= '1;
        end else if (commit) begin
            for (int s = 0; s < PAGE_N; s++) begin
                if (slot_vld[s]) begin
                    mem[{page_sel, PAGE_W'(s)}] <= slot_data[s*DATA_W +: DATA_W];
                end
            end
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '1;
        else        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/pgw_top.sv
`timescale 1ns/1ps
// pgw_top: paged write-commit buffer. It gates the front-end strobes with
// busy, collects bytes in a page buffer, starts the programming window on a
// stop that has data pending, and commits the page when the window ends.
// It assumes that the strobes are single-cycle pulses synchronous to clk.
module pgw_top #(
    parameter int ADDR_W    = pgw_pkg::DEF_ADDR_W,
    parameter int DATA_W    = pgw_pkg::DEF_DATA_W,
    parameter int PAGE_W    = pgw_pkg::DEF_PAGE_W,
    parameter int WR_CYCLES = pgw_pkg::DEF_WR_CYCLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              data_stb,
    input  logic [DATA_W-1:0] data_in,
    input  logic              stop_pulse,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic [ADDR_W-1:0] ptr_out
);
    localparam int PAGE_N = 1 << PAGE_W;

    logic                     acc_load, acc_data, acc_stop, start, commit;
    logic [PAGE_N*DATA_W-1:0] slot_data;
    logic [PAGE_N-1:0]        slot_vld;

    // Event acceptance: everything is ignored while busy; a load beats data.
    always_comb begin
        acc_load = addr_load && !busy;
        acc_data = data_stb && !busy && !addr_load;
        acc_stop = stop_pulse && !busy;
        start    = acc_stop && ((|slot_vld) || acc_data) && !acc_load;
    end

    pgw_pointer #(.ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .acc_load(acc_load), .addr_in(addr_in),
        .acc_data(acc_data), .ptr(ptr_out)
    );

    pgw_pagebuf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(acc_load || commit), .wr(acc_data),
        .slot(ptr_out[PAGE_W-1:0]), .wdata(data_in),
        .slot_data(slot_data), .slot_vld(slot_vld)
    );

    pgw_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .commit(commit)
    );

    pgw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .commit(commit),
        .page_sel(ptr_out[ADDR_W-1:PAGE_W]), .slot_data(slot_data),
        .slot_vld(slot_vld), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/pgw_chk.sv
`timescale 1ns/1ps
// pgw_chk: port-level properties of pgw_top. The window length is checked
// with a counter, and pending data is tracked from the strobes.
module pgw_chk #(
    parameter int ADDR_W    = 8,
    parameter int PAGE_W    = 4,
    parameter int WR_CYCLES = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_load,
    input logic [ADDR_W-1:0] addr_in,
    input logic              data_stb,
    input logic              stop_pulse,
    input logic              busy,
    input logic [ADDR_W-1:0] ptr_out
);
    int   run_cnt;
    logic pend;

    // Count the cycles of the current busy window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_cnt <= 0;
        else                 run_cnt <= run_cnt + 1;
    end

    // Track whether a data byte is waiting since the last load or window.
    always_ff @(posedge clk) begin
        if (!rst_n || busy || (addr_load && !busy)) pend <= 1'b0;
        else if (data_stb)                          pend <= 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && ptr_out == '0));

    // R2
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_load && !busy) |=> (ptr_out == $past(addr_in)));

    // R3
    page_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_stb && !addr_load && !busy) |=>
        ((ptr_out[ADDR_W-1:PAGE_W] == $past(ptr_out[ADDR_W-1:PAGE_W])) &&
         (ptr_out[PAGE_W-1:0] == PAGE_W'($past(ptr_out[PAGE_W-1:0]) + 1'b1))));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_pulse));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == WR_CYCLES));

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < WR_CYCLES));

    // R6
    empty_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pulse && !busy && !pend && !data_stb) |=> !busy);

    // R8
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ptr_out));
endmodule

bind pgw_top pgw_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .data_stb(data_stb), .stop_pulse(stop_pulse), .busy(busy), .ptr_out(ptr_out)
);

// File: tb/sim_pgw_top.sv
`timescale 1ns/1ps
module sim_pgw_top;
    localparam int WR = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0, data_stb = 1'b0, stop_pulse = 1'b0;
    logic [7:0] addr_in = '0, data_in = '0, rd_addr = '0;
    logic [7:0] rd_data, ptr_out;
    logic       busy;

    int n_run = 0, n_fail = 0;

    logic [7:0] m_mem [256];
    logic [7:0] m_buf [16];
    logic [15:0] m_vld;
    logic [7:0] m_ptr;

    always #10 clk = ~clk;

    pgw_top #(.WR_CYCLES(WR)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
        .data_stb(data_stb), .data_in(data_in), .stop_pulse(stop_pulse),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .ptr_out(ptr_out)
    );

    function automatic logic [7:0] nxt(input logic [7:0] p);
        return {p[7:4], p[3:0] + 4'd1};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [7:0] a);
        addr_load = 1'b1; addr_in = a;
        @(negedge clk);
        addr_load = 1'b0;
        m_ptr = a; m_vld = '0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        data_stb = 1'b1; data_in = d;
        @(negedge clk);
        data_stb = 1'b0;
        m_buf[m_ptr[3:0]] = d; m_vld[m_ptr[3:0]] = 1'b1; m_ptr = nxt(m_ptr);
    endtask

    task automatic rd_chk(input logic [7:0] a, input string req);
        rd_addr = a;
        @(negedge clk);
        chk(rd_data == m_mem[a], req, rd_data, m_mem[a]);
    endtask

    // Stop (optionally with a same-cycle byte); inject ignored events mid-window.
    task automatic do_stop(input bit with_byte, input logic [7:0] d, input bit inject);
        int cnt;
        logic [7:0] probe;
        stop_pulse = 1'b1;
        if (with_byte) begin data_stb = 1'b1; data_in = d; end
        @(negedge clk);
        stop_pulse = 1'b0; data_stb = 1'b0;
        if (with_byte) begin
            m_buf[m_ptr[3:0]] = d; m_vld[m_ptr[3:0]] = 1'b1; m_ptr = nxt(m_ptr);
        end
        if (m_vld == '0) begin
            chk(busy == 1'b0, "R6 no window", busy, 0);
            chk(ptr_out == m_ptr, "R6 pointer kept", ptr_out, m_ptr);
            return;
        end
        chk(busy == 1'b1, "R5 busy rises", busy, 1);
        probe = {m_ptr[7:4], 4'd0};
        for (int s = 0; s < 16; s++) if (m_vld[s]) probe = {m_ptr[7:4], 4'(s)};
        cnt = 0;
        while (busy && cnt < 10 * WR) begin
            if (inject && cnt == 2) begin
                addr_load = 1'b1; addr_in = 8'hC3; data_stb = 1'b1;
                data_in = 8'h5A; stop_pulse = 1'b1;
            end
            if (inject && cnt == 3) begin
                addr_load = 1'b0; data_stb = 1'b0; stop_pulse = 1'b0;
                rd_addr = probe;
            end
            if (inject && cnt == 4)
                chk(rd_data == m_mem[probe], "R7 old data during window", rd_data, m_mem[probe]);
            cnt++;
            @(negedge clk);
        end
        chk(cnt == WR, "R5 window length", cnt, WR);
        for (int s = 0; s < 16; s++)
            if (m_vld[s]) m_mem[{m_ptr[7:4], 4'(s)}] = m_buf[s];
        m_vld = '0;
        chk(ptr_out == m_ptr, inject ? "R8 pointer after ignored events" : "R9 pointer after commit",
            ptr_out, m_ptr);
        if (inject) begin
            stop_pulse = 1'b1;
            @(negedge clk);
            stop_pulse = 1'b0;
            chk(busy == 1'b0, "R8 no data kept from window", busy, 0);
        end
    endtask

    task automatic page_chk(input logic [7:0] base, input string req);
        for (int i = 0; i < 16; i++) rd_chk({base[7:4], 4'(i)}, req);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = 8'hFF;
        m_vld = '0; m_ptr = '0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(ptr_out == 8'h00, "R1 pointer", ptr_out, 0);
        rd_chk(8'h00, "R1 erased");
        rd_chk(8'hA7, "R11 read port");

        // R2 / R6: address only, then stop
        do_load(8'h25);
        chk(ptr_out == 8'h25, "R2 load", ptr_out, 8'h25);
        do_stop(1'b0, 8'h00, 1'b0);
        rd_chk(8'h25, "R6 array unchanged");

        // R3 / R7 / R9: wrap across slot 15 inside page 2
        do_load(8'h2E);
        do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3);
        chk(ptr_out == 8'h21, "R3 in-page wrap", ptr_out, 8'h21);
        do_stop(1'b0, 8'h00, 1'b0);
        page_chk(8'h20, "R7 masked commit");

        // R4: 18 bytes overwrite the first two slots
        do_load(8'h50);
        for (int i = 0; i < 18; i++) do_byte(8'(8'h10 + i));
        do_stop(1'b0, 8'h00, 1'b0);
        page_chk(8'h50, "R4 overwrite");

        // R2: load discards pending bytes
        do_byte(8'hEE);
        do_load(8'h64);
        do_stop(1'b0, 8'h00, 1'b0);
        rd_chk(8'h52, "R2 discarded byte");

        // R7 / R8: events during window ignored, old data readable
        do_load(8'h83);
        do_byte(8'h3C); do_byte(8'h4D);
        do_stop(1'b0, 8'h00, 1'b1);
        page_chk(8'h80, "R8 array after window");
        rd_chk(8'hC3, "R8 injected address untouched");

        // R10: byte with stop is committed
        do_load(8'h7F);
        do_stop(1'b1, 8'h99, 1'b0);
        rd_chk(8'h7F, "R10 byte with stop");
        chk(ptr_out == 8'h70, "R10 pointer", ptr_out, 8'h70);

        // R10: byte with load is dropped
        addr_load = 1'b1; addr_in = 8'h91; data_stb = 1'b1; data_in = 8'h42;
        @(negedge clk);
        addr_load = 1'b0; data_stb = 1'b0;
        m_ptr = 8'h91; m_vld = '0;
        chk(ptr_out == 8'h91, "R10 load beats data", ptr_out, 8'h91);
        do_stop(1'b0, 8'h00, 1'b0);
        rd_chk(8'h91, "R10 dropped byte");

        // Random sequences checked against the bench model
        for (int t = 0; t < 30; t++) begin
            int n;
            logic [7:0] a;
            a = 8'($urandom);
            n = $urandom_range(0, 20);
            do_load(a);
            for (int k = 0; k < n; k++) do_byte(8'($urandom));
            do_stop(($urandom % 4) == 0, 8'($urandom), 1'b0);
            page_chk(a, "R7 random page");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule